// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block recovers HDLC frames from a serial bit stream that arrives one bit per `bit_vld` strobe. It searches for the 01111110 flag, removes the zero that a sender inserts after every run of five ones, and packs the remaining payload bits into bytes, least significant bit first. The two frame check bytes at the end of each frame are checked against the CCITT CRC-16 and are never passed on. Each payload byte goes out on a one-cycle write strobe to an external FIFO, together with a two-bit tag that marks the first byte, middle bytes, and a good or bad last byte.

Frames that are too short are either dropped or tagged as bad according to their exact length in destuffed bits. Aborts, go-ahead patterns and an idle line are detected from a single running count of consecutive ones. The receive enable turns the receiver on and off on its own: while it is low, the receiver ignores the line and drops back to searching for a flag.

Top module: `hdlc_frame_rx`

## Requirements
- R1: While no flag (a 0, six 1s, a 0) has been seen since reset or enable, incoming bits produce no FIFO write.
- R2: Inside a frame, a 0 that follows five consecutive 1s is discarded and not counted as a frame bit; a payload of all-ones bytes is therefore recovered unchanged.
- R3: A frame whose length between flags, counted in destuffed bits, is below 25 produces no FIFO write at all.
- R4: A frame of 25 to 31 destuffed bits writes its one complete payload byte, tagged 11 (last, bad).
- R5: A frame of 32 or more bits is judged by a CRC register preset to 0xFFFF, polynomial x^16+x^12+x^5+1 in reflected form (0x8408), and fed LSB first with every frame bit including the check bytes. The last payload byte is tagged 10 (last, good) only when the register holds 0xF0B8 at the closing flag and the length is a multiple of 8. Otherwise it is tagged 11. In every case, the final 16 bits (the check bytes) are never written.
- R6: Payload byte j of a frame is built from frame bits 8j..8j+7, LSB first. The first byte written is tagged 01 and the later ones 00, except that the final byte always carries a last-byte tag (10 or 11).
- R7: A seventh consecutive 1 inside a frame is an abort if at least 26 destuffed bits have been taken since the opening flag. This count includes any trailing data ones and the first five ones of the run. On an abort, abort_o pulses for one cycle and the pending byte, if one is held, is written tagged 11. In all cases the receiver then searches for a new flag.
- R8: A 0 that arrives after exactly seven consecutive 1s pulses goahead_o for one cycle. A 0 after eight or more 1s does not pulse it.
- R9: idle_o goes high when the fifteenth consecutive 1 is taken, and stays high until a 0 is taken.
- R10: After reset, all outputs are low. A write or status pulse appears in the cycle after the clock edge that takes the strobed bit. While rx_en is low, strobes are ignored and the receiver returns to flag search.
- R11: The closing flag of one frame also opens the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| bit_vld | input | 1 | Strobe: bit_in is taken at this clock edge |
| bit_in | input | 1 | Serial line bit |
| wr_en | output | 1 | One-cycle FIFO write strobe |
| wr_data | output | 8 | Payload byte |
| wr_tag | output | 2 | 00 middle, 01 first, 10 last good, 11 last bad/aborted |
| idle_o | output | 1 | Fifteen or more consecutive ones on the line |
| abort_o | output | 1 | One-cycle pulse on a qualifying abort |
| goahead_o | output | 1 | One-cycle pulse on 0 after exactly seven ones |

## Verification
Two events can fall on the same bit: the closing-flag judgement of one frame, which writes its tagged last byte, and the opening of the next frame, which clears the counters and presets the CRC. Back-to-back frames that share a single flag provoke this. Each frame's bytes and tags are then compared with values derived from its own bits. Abort and go-ahead also arise from one run of ones: the sweep ends frames of many lengths with exactly seven ones followed by a 0. It expects the abort pulse, the aborted last byte and the go-ahead pulse to come from the abort length arithmetic.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    TAG_MID      = 2'b00,
    TAG_FIRST    = 2'b01,
    TAG_LAST_OK  = 2'b10,
    TAG_LAST_BAD = 2'b11
  } rx_tag_e;

  // per-bit line events decoded from the run of ones
  typedef struct packed {
    logic push;   // destuffed bit to be kept
    logic flag;   // closing 0 of a flag
    logic abort;  // seventh consecutive one
  } line_ev_t;

endpackage

// File: rtl/hdlc_rx_linecode.sv
module hdlc_rx_linecode
  import hdlc_rx_pkg::*;
#(
  parameter int RUN_STUFF = 5,
  parameter int IDLE_RUN  = 15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     stb,
  input  logic     bit_i,
  output line_ev_t ev,
  output logic     idle,
  output logic     goahead
);

  localparam int ONES_W = $clog2(IDLE_RUN + 1);
  localparam logic [ONES_W-1:0] K_STUFF = ONES_W'(RUN_STUFF);
  localparam logic [ONES_W-1:0] K_FLAG  = ONES_W'(RUN_STUFF + 1);
  localparam logic [ONES_W-1:0] K_ABORT = ONES_W'(RUN_STUFF + 2);
  localparam logic [ONES_W-1:0] K_IDLE  = ONES_W'(IDLE_RUN);

  logic [ONES_W-1:0] ones_q, ones_n;
  logic              ga_q, ga_n;

  always_comb begin
    ev     = '0;
    ones_n = ones_q;
    ga_n   = 1'b0;
    if (!en) begin
      ones_n = '0;
    end else if (stb) begin
      ev.push = (ones_q < K_STUFF);
      if (bit_i) begin
        ones_n   = (ones_q == K_IDLE) ? ones_q : ones_q + 1'b1;
        ev.abort = (ones_q == K_FLAG);
      end else begin
        ones_n  = '0;
        ev.flag = (ones_q == K_FLAG);
        ga_n    = (ones_q == K_ABORT);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      ga_q   <= 1'b0;
    end else begin
      ones_q <= ones_n;
      ga_q   <= ga_n;
    end
  end

  assign idle    = (ones_q == K_IDLE);
  assign goahead = ga_q;

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int              W      = 16,
  parameter logic [W-1:0]    POLY   = 16'h8408,
  parameter logic [W-1:0]    PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q, crc_n;
  logic         fb;

  always_comb begin
    fb    = crc_q[0] ^ bit_i;
    crc_n = crc_q;
    if (clr) begin
      crc_n = PRESET;
    end else if (en) begin
      crc_n = (crc_q >> 1) ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_n;
  end

  assign crc = crc_q;

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int MIN_LEN   = 25,
  parameter int FULL_LEN  = 32,
  parameter int ABORT_LEN = 26,
  parameter int HOLD      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  input  logic              bit_i,
  input  line_ev_t          ev,
  input  logic              crc_ok,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              crc_bit,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wr_tag,
  output logic              abort_p
);

  localparam int PIPE   = FCS_W / DATA_W + 1;
  localparam int CNT_W  = $clog2(FULL_LEN) + 1;
  localparam int TOT_W  = CNT_W + 1;
  localparam int FILL_W = $clog2(HOLD + 1);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BC_W   = $clog2(PIPE + 1);
  localparam logic [CNT_W-1:0]  K_MIN   = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0]  K_FULL  = CNT_W'(FULL_LEN);
  localparam logic [TOT_W-1:0]  K_ABORT = TOT_W'(ABORT_LEN);
  localparam logic [FILL_W-1:0] K_HOLD  = FILL_W'(HOLD);
  localparam logic [IDX_W-1:0]  K_LAST  = IDX_W'(DATA_W - 1);
  localparam logic [BC_W-1:0]   K_PIPE  = BC_W'(PIPE);

  logic                        in_q, in_n;
  logic [HOLD-1:0]             dl_q, dl_n;
  logic [FILL_W-1:0]           fill_q, fill_n;
  logic [DATA_W-1:0]           asm_q, asm_n;
  logic [IDX_W-1:0]            idx_q, idx_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n;
  logic [PIPE-1:0][DATA_W-1:0] pipe_q, pipe_n;
  logic [BC_W-1:0]             bc_q, bc_n;
  logic                        first_q, first_n;
  logic                        we_q, we_n;
  logic [DATA_W-1:0]           wd_q, wd_n;
  rx_tag_e                     wt_q, wt_n;
  logic                        ab_q, ab_n;
  logic                        held;
  logic [TOT_W-1:0]            taken;

  assign held    = (bc_q == K_PIPE);
  assign taken   = {1'b0, cnt_q} + TOT_W'(fill_q);
  assign crc_bit = dl_q[HOLD-1];

  always_comb begin
    in_n    = in_q;
    dl_n    = dl_q;
    fill_n  = fill_q;
    asm_n   = asm_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    pipe_n  = pipe_q;
    bc_n    = bc_q;
    first_n = first_q;
    we_n    = 1'b0;
    wd_n    = wd_q;
    wt_n    = wt_q;
    ab_n    = 1'b0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    if (!en) begin
      in_n = 1'b0;
    end else if (stb) begin
      if (ev.flag) begin
        // judge the frame that ends here, then open the next one
        if (in_q && (cnt_q >= K_MIN) && held) begin
          we_n = 1'b1;
          wd_n = pipe_q[PIPE-1];
          wt_n = ((cnt_q >= K_FULL) && (idx_q == '0) && crc_ok) ? TAG_LAST_OK : TAG_LAST_BAD;
        end
        in_n    = 1'b1;
        fill_n  = '0;
        idx_n   = '0;
        cnt_n   = '0;
        bc_n    = '0;
        first_n = 1'b1;
        crc_clr = 1'b1;
      end else if (ev.abort && in_q) begin
        in_n = 1'b0;
        if (taken >= K_ABORT) begin
          ab_n = 1'b1;
          if (held) begin
            we_n = 1'b1;
            wd_n = pipe_q[PIPE-1];
            wt_n = TAG_LAST_BAD;
          end
        end
      end else if (ev.push && in_q) begin
        dl_n = {dl_q[HOLD-2:0], bit_i};
        if (fill_q != K_HOLD) begin
          fill_n = fill_q + 1'b1;
        end else begin
          // oldest held bit is now known to be frame content
          crc_en = 1'b1;
          asm_n  = {dl_q[HOLD-1], asm_q[DATA_W-1:1]};
          idx_n  = idx_q + 1'b1;
          if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
          if (idx_q == K_LAST) begin
            pipe_n = {pipe_q[PIPE-2:0], asm_n};
            if (held) begin
              we_n    = 1'b1;
              wd_n    = pipe_q[PIPE-1];
              wt_n    = first_q ? TAG_FIRST : TAG_MID;
              first_n = 1'b0;
            end else begin
              bc_n = bc_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      dl_q    <= '0;
      fill_q  <= '0;
      asm_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      pipe_q  <= '0;
      bc_q    <= '0;
      first_q <= 1'b1;
      we_q    <= 1'b0;
      wd_q    <= '0;
      wt_q    <= TAG_MID;
      ab_q    <= 1'b0;
    end else begin
      in_q    <= in_n;
      dl_q    <= dl_n;
      fill_q  <= fill_n;
      asm_q   <= asm_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      pipe_q  <= pipe_n;
      bc_q    <= bc_n;
      first_q <= first_n;
      we_q    <= we_n;
      wd_q    <= wd_n;
      wt_q    <= wt_n;
      ab_q    <= ab_n;
    end
  end

  assign wr_en   = we_q;
  assign wr_data = wd_q;
  assign wr_tag  = wt_q;
  assign abort_p = ab_q;

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int RUN_STUFF = 5,
  parameter int IDLE_RUN  = 15,
  parameter int MIN_LEN   = 25,
  parameter int FULL_LEN  = 32,
  parameter int ABORT_LEN = 26,
  parameter logic [FCS_W-1:0] CRC_POLY    = 16'h8408,
  parameter logic [FCS_W-1:0] CRC_PRESET  = 16'hFFFF,
  parameter logic [FCS_W-1:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wr_tag,
  output logic              idle_o,
  output logic              abort_o,
  output logic              goahead_o
);

  localparam int HOLD = RUN_STUFF + 1;

  line_ev_t          ev;
  logic              crc_clr, crc_en, crc_bit;
  logic [FCS_W-1:0]  crc;

  hdlc_rx_linecode #(
    .RUN_STUFF (RUN_STUFF),
    .IDLE_RUN  (IDLE_RUN)
  ) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .stb     (bit_vld),
    .bit_i   (bit_in),
    .ev      (ev),
    .idle    (idle_o),
    .goahead (goahead_o)
  );

  hdlc_rx_crc #(
    .W      (FCS_W),
    .POLY   (CRC_POLY),
    .PRESET (CRC_PRESET)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .bit_i (crc_bit),
    .crc   (crc)
  );

  hdlc_rx_framer #(
    .DATA_W    (DATA_W),
    .FCS_W     (FCS_W),
    .MIN_LEN   (MIN_LEN),
    .FULL_LEN  (FULL_LEN),
    .ABORT_LEN (ABORT_LEN),
    .HOLD      (HOLD)
  ) u_frm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .stb     (bit_vld),
    .bit_i   (bit_in),
    .ev      (ev),
    .crc_ok  (crc == CRC_RESIDUE),
    .crc_clr (crc_clr),
    .crc_en  (crc_en),
    .crc_bit (crc_bit),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_tag  (wr_tag),
    .abort_p (abort_o)
  );

endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       bit_vld,
  input logic       bit_in,
  input logic       wr_en,
  input logic [1:0] wr_tag,
  input logic       idle_o,
  input logic       abort_o,
  input logic       goahead_o
);

  a_r10_off_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !wr_en);

  a_r10_write_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(bit_vld && rx_en));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !wr_en);

  a_r9_idle_rise_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(bit_vld && bit_in));

  a_r8_goahead_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    goahead_o |-> $past(bit_vld && !bit_in));

  a_r7_abort_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(bit_vld && bit_in));

  a_r7_abort_tag_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && wr_en) |-> (wr_tag == 2'b11));

  a_r8_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !goahead_o);

endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk u_chk (.*);

// File: tb/tb_hdlc_frame_rx.sv
module tb_hdlc_frame_rx;

  logic       clk = 1'b0;
  logic       rst_n, rx_en, bit_vld, bit_in;
  logic       wr_en, idle_o, abort_o, goahead_o;
  logic [7:0] wr_data;
  logic [1:0] wr_tag;

  always #5 clk = ~clk;

  hdlc_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .idle_o(idle_o), .abort_o(abort_o), .goahead_o(goahead_o)
  );

  int          total_n = 0;
  int          bad_n   = 0;
  logic [9:0]  got [0:63];
  int          got_n = 0;
  int          ab_n  = 0;
  int          ga_n  = 0;
  bit          fb [0:127];
  logic [15:0] lf;
  int          ones_tx;
  bit          done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en && got_n < 64) begin
        got[got_n] = {wr_tag, wr_data};
        got_n++;
      end
      if (abort_o)   ab_n++;
      if (goahead_o) ga_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_raw(input bit b);
    @(negedge clk);
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    ones_tx = 0;
  endtask

  task automatic send_data(input int from, input int to);
    for (int i = from; i < to; i++) begin
      send_raw(fb[i]);
      if (fb[i]) ones_tx++; else ones_tx = 0;
      if (ones_tx == 5) begin
        send_raw(1'b0);
        ones_tx = 0;
      end
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] crc_res(input int n);
    logic [15:0] c;
    logic        f;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      f = c[0] ^ fb[i];
      c = c >> 1;
      if (f) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fb[i] = lf[0];
    end
  endtask

  task automatic build_good(input int k, input bit all_ones);
    logic [15:0] f;
    if (all_ones) for (int i = 0; i < 8 * k; i++) fb[i] = 1'b1;
    else          fill_rand(8 * k);
    f = ~crc_res(8 * k);
    for (int j = 0; j < 16; j++) fb[8 * k + j] = f[j];
  endtask

  task automatic expect_frame(input string req, input bit emit, input int nb, input bit good);
    int cnt;
    cnt = emit ? (nb / 8 - 2) : 0;
    chk({req, " write count"}, got_n, cnt);
    for (int j = 0; j < cnt && j < got_n; j++) begin
      logic [7:0] eb;
      logic [1:0] et;
      for (int b = 0; b < 8; b++) eb[b] = fb[j * 8 + b];
      if (j == cnt - 1) et = good ? 2'b10 : 2'b11;
      else              et = (j == 0) ? 2'b01 : 2'b00;
      chk({req, " R6 byte"}, int'(got[j][7:0]), int'(eb));
      chk({req, " R6 tag"},  int'(got[j][9:8]), int'(et));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total_n++;
      bad_n++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  initial begin
    int ab0, ga0, tot, n;
    bit good;
    rst_n = 1'b0; rx_en = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    lf = 16'hACE1; ones_tx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R10 reset state
    chk("R10 reset wr_en", int'(wr_en), 0);
    chk("R10 reset idle", int'(idle_o), 0);
    chk("R10 reset abort", int'(abort_o), 0);
    chk("R10 reset goahead", int'(goahead_o), 0);

    // R1: no flag yet, nothing written
    rx_en = 1'b1;
    got_n = 0;
    for (int i = 0; i < 48; i++) send_raw((i % 3) != 2);
    settle();
    chk("R1 no write before flag", got_n, 0);

    // R3 R4 R5 sweep of frame lengths 0..48 bits
    for (int len = 0; len <= 48; len++) begin
      fill_rand(len);
      good = (len >= 32) && (len % 8 == 0) && (crc_res(len) == 16'hF0B8);
      got_n = 0;
      send_flag();
      send_data(0, len);
      send_flag();
      settle();
      if (len < 25)      expect_frame("R3", 1'b0, len, good);
      else if (len < 32) expect_frame("R4", 1'b1, len, 1'b0);
      else               expect_frame("R5", 1'b1, len, good);
    end

    // R11 R5: good frames sharing one flag between them
    send_flag();
    for (int k = 1; k <= 6; k++) begin
      build_good(k, 1'b0);
      n = 8 * k + 16;
      got_n = 0;
      send_data(0, n);
      send_flag();
      settle();
      expect_frame("R11 R5 shared flag", n >= 25, n, 1'b1);
    end

    // R2: all-ones payload needs stuffing throughout
    build_good(4, 1'b1);
    got_n = 0;
    send_data(0, 48);
    send_flag();
    settle();
    expect_frame("R2 stuffing", 1'b1, 48, 1'b1);

    // R5: one flipped bit gives a bad last byte
    build_good(4, 1'b0);
    fb[5] = ~fb[5];
    got_n = 0;
    send_data(0, 48);
    send_flag();
    settle();
    expect_frame("R5 bad crc", 1'b1, 48, crc_res(48) == 16'hF0B8);

    // R7 R8: abort sweep, with and without trailing data ones
    for (int t = 0; t <= 3; t += 3) begin
      for (int k = 16; k <= 40; k++) begin
        fill_rand(k);
        fb[k - 1 - t] = 1'b0;
        for (int i = k - t; i < k; i++) fb[i] = 1'b1;
        ab0 = ab_n; ga0 = ga_n;
        got_n = 0;
        send_flag();
        send_data(0, k);
        for (int i = 0; i < 7 - t; i++) send_raw(1'b1);
        send_raw(1'b0);
        settle();
        tot = k + 5 - t;
        expect_frame("R7 abort", (tot >= 26) && (tot - 6 >= 24), tot - 6, 1'b0);
        chk("R7 abort pulse", ab_n - ab0, (tot >= 26) ? 1 : 0);
        chk("R8 goahead after seven ones", ga_n - ga0, 1);
      end
    end

    // R8: eight ones then zero is not a go-ahead
    ga0 = ga_n; ab0 = ab_n;
    send_raw(1'b0);
    for (int i = 0; i < 8; i++) send_raw(1'b1);
    send_raw(1'b0);
    settle();
    chk("R8 no goahead after eight ones", ga_n - ga0, 0);
    chk("R7 no abort outside frame", ab_n - ab0, 0);

    // R9: idle threshold
    for (int i = 0; i < 14; i++) send_raw(1'b1);
    settle();
    chk("R9 idle low at 14 ones", int'(idle_o), 0);
    send_raw(1'b1);
    settle();
    chk("R9 idle high at 15 ones", int'(idle_o), 1);
    for (int i = 0; i < 5; i++) send_raw(1'b1);
    settle();
    chk("R9 idle held", int'(idle_o), 1);
    send_raw(1'b0);
    settle();
    chk("R9 idle cleared by zero", int'(idle_o), 0);

    // R10: receiver disabled ignores a whole frame
    rx_en = 1'b0;
    build_good(3, 1'b0);
    got_n = 0;
    send_flag();
    send_data(0, 40);
    send_flag();
    settle();
    chk("R10 disabled no write", got_n, 0);
    rx_en = 1'b1;

    // R10: disable mid-frame drops back to flag search
    build_good(4, 1'b0);
    got_n = 0;
    send_flag();
    send_data(0, 20);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    send_data(20, 48);
    send_flag();
    settle();
    chk("R10 mid-frame disable drops frame", got_n, 0);
    build_good(2, 1'b0);
    got_n = 0;
    send_data(0, 32);
    send_flag();
    settle();
    expect_frame("R10 R1 frame after re-enable", 1'b1, 32, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

endmodule